// File: doc/BRIEF.md
# Circular Return-Address Stack

This block keeps return addresses for a small processor core. A subroutine call or an interrupt entry pushes the address the core must resume at. Any of the three return flavours (plain return, return loading a literal, return from interrupt) pops one address. The stack sits apart from program and data memory. No register exposes its pointer.

Storage is a ring of `DEPTH` entries, each `DATA_W` bits wide (8 by 13 by default). The pointer wraps with no error detection. A ninth push therefore overwrites the oldest entry, and popping past the bottom returns whatever stale value occupies that slot. The entry that would be popped is always shown on `pop_data_o` as a combinational read. The core samples it in the cycle it raises `pop_i`, and the pointer moves back at the clock edge.

Top module: `ret_stack`

## Requirements
- R1: An active-low asynchronous reset returns the pointer to slot 0 and leaves the entries untouched. Right after reset, `pop_data_o` shows slot DEPTH-1.
- R2: A push writes `push_data_i` into the slot at the pointer and advances the pointer by one modulo DEPTH. From the next cycle, `pop_data_o` shows the pushed value.
- R3: `pop_data_o` always shows the slot at the pointer minus one modulo DEPTH. A pop, with no push in the same cycle, moves the pointer back by one modulo DEPTH.
- R4: Nested pushes and pops return addresses in last-in first-out order.
- R5: After DEPTH pushes, each further push silently overwrites the oldest stored entry, so the ninth push replaces the first.
- R6: Popping more times than values were pushed wraps the pointer and returns the stale contents of the slots, with no error indication.
- R7: When push and pop are asserted in the same cycle, the push takes effect and the pop is ignored.
- R8: In a cycle with neither push nor pop, the pointer and all entries keep their values, so `pop_data_o` is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Push strobe (call or interrupt entry) |
| push_data_i | input | DATA_W | Return address to store |
| pop_i | input | 1 | Pop strobe (any return) |
| pop_data_o | output | DATA_W | Address at the top of the stack |

## Verification
A short nested call/return sequence separates correct last-in first-out ordering from a queue or a stuck pointer. Ten pushes followed by ten pops expose the wrap in both directions. This shows whether the oldest entries are overwritten and whether popping past the bottom recirculates stale slots, not stalling or reading zeros. Colliding push/pop strobes, idle gaps and a reset applied with the stack partly filled show the priority rule, the hold behaviour, and that reset clears only the pointer. Long random strobe mixes with random addresses are compared cycle by cycle against a reference ring kept in the bench.

// File: rtl/ret_stack_pkg.sv
`timescale 1ns/1ps
package ret_stack_pkg;

  typedef enum logic [1:0] {
    STK_IDLE = 2'd0,
    STK_PUSH = 2'd1,
    STK_POP  = 2'd2
  } stk_op_e;

  // push has priority over pop when both strobes are raised
  function automatic stk_op_e stk_decode(input logic push, input logic pop);
    if (push)     return STK_PUSH;
    else if (pop) return STK_POP;
    else          return STK_IDLE;
  endfunction

endpackage

// File: rtl/ret_stack_ptr.sv
`timescale 1ns/1ps
module ret_stack_ptr #(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  ret_stack_pkg::stk_op_e op_i,
  output logic [PTR_W-1:0]       wr_idx_o,
  output logic [PTR_W-1:0]       rd_idx_o
);
  import ret_stack_pkg::*;

  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] ptr_inc;
  logic [PTR_W-1:0] ptr_dec;

  // DEPTH is a power of two, so truncation is the modulo wrap
  assign ptr_inc = ptr_q + PTR_W'(1);
  assign ptr_dec = ptr_q - PTR_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else begin
      unique case (op_i)
        STK_PUSH: ptr_q <= ptr_inc;
        STK_POP:  ptr_q <= ptr_dec;
        default:  ptr_q <= ptr_q;
      endcase
    end
  end

  assign wr_idx_o = ptr_q;
  assign rd_idx_o = ptr_dec;

  initial begin
    if ((1 << PTR_W) != DEPTH || DEPTH < 2)
      $error("ret_stack_ptr: DEPTH must be a power of two");
  end

  AST_PUSH_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == STK_PUSH |=> wr_idx_o != $past(wr_idx_o) && rd_idx_o == $past(wr_idx_o)); // R2
  AST_POP_RETREAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == STK_POP |=> wr_idx_o == $past(rd_idx_o)); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == STK_IDLE |=> $stable(wr_idx_o)); // R8

endmodule

// File: rtl/ret_stack_mem.sv
`timescale 1ns/1ps
module ret_stack_mem #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 13,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [PTR_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [PTR_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o
);

  logic [DATA_W-1:0] slot_q [DEPTH];
  logic [DEPTH-1:0]  slot_we;

  // entries carry no reset: contents are undefined until written
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    assign slot_we[g] = we_i && (wr_idx_i == PTR_W'(g));
    always_ff @(posedge clk_i) begin
      if (slot_we[g]) slot_q[g] <= wr_data_i;
    end
  end

  assign rd_data_o = slot_q[rd_idx_i];

  AST_ONE_SLOT_WRITE: assert property (@(posedge clk_i)
    $onehot0(slot_we) && (we_i == (slot_we != '0))); // R5

endmodule

// File: rtl/ret_stack.sv
`timescale 1ns/1ps
module ret_stack #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 13,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] pop_data_o
);
  import ret_stack_pkg::*;

  stk_op_e          op;
  logic [PTR_W-1:0] wr_idx;
  logic [PTR_W-1:0] rd_idx;

  assign op = stk_decode(push_i, pop_i);

  ret_stack_ptr #(
    .DEPTH (DEPTH)
  ) u_ptr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .op_i     (op),
    .wr_idx_o (wr_idx),
    .rd_idx_o (rd_idx)
  );

  ret_stack_mem #(
    .DEPTH  (DEPTH),
    .DATA_W (DATA_W)
  ) u_mem (
    .clk_i     (clk_i),
    .we_i      (op == STK_PUSH),
    .wr_idx_i  (wr_idx),
    .wr_data_i (push_data_i),
    .rd_idx_i  (rd_idx),
    .rd_data_o (pop_data_o)
  );

  AST_PUSH_VISIBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> pop_data_o == $past(push_data_i)); // R2
  AST_COLLIDE_PUSH_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && pop_i |=> pop_data_o == $past(push_data_i)); // R7
  AST_IDLE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !push_i && !pop_i |=> $stable(pop_data_o)); // R8

endmodule

// File: tb/ret_stack_tb_top.sv
`timescale 1ns/1ps
module ret_stack_tb_top;
  localparam int DEPTH  = 8;
  localparam int DATA_W = 13;
  localparam int PTR_W  = $clog2(DEPTH);

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              push_i = 1'b0;
  logic [DATA_W-1:0] push_data_i = '0;
  logic              pop_i = 1'b0;
  logic [DATA_W-1:0] pop_data_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [DATA_W-1:0] m_slot [DEPTH];
  bit                m_valid [DEPTH];
  logic [PTR_W-1:0]  m_ptr = '0;

  always #4 clk_i = ~clk_i;

  ret_stack #(.DEPTH(DEPTH), .DATA_W(DATA_W)) dut_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push_i),
    .push_data_i (push_data_i),
    .pop_i       (pop_i),
    .pop_data_o  (pop_data_o)
  );

  function automatic logic [PTR_W-1:0] top_idx(input logic [PTR_W-1:0] p);
    return p - PTR_W'(1);
  endfunction

  task automatic check(input string tag, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: pop_data_o=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive at negedge, compare the combinational top, then apply the edge to the model
  task automatic step(input string tag, input bit psh, input bit pp,
                      input logic [DATA_W-1:0] d);
    logic [PTR_W-1:0] t;
    @(negedge clk_i);
    push_i = psh; pop_i = pp; push_data_i = d;
    #1;
    t = top_idx(m_ptr);
    if (m_valid[t]) check(tag, pop_data_o, m_slot[t]);
    @(posedge clk_i);
    if (psh) begin
      m_slot[m_ptr]  = d;
      m_valid[m_ptr] = 1'b1;
      m_ptr = m_ptr + PTR_W'(1);
    end else if (pp) begin
      m_ptr = m_ptr - PTR_W'(1);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    push_i = 1'b0; pop_i = 1'b0;
    rst_ni = 1'b0;
    m_ptr  = '0;
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [DATA_W-1:0] snap;
    void'($urandom(32'hC0FFEE));
    for (int i = 0; i < DEPTH; i++) m_valid[i] = 1'b0;
    do_reset();

    // R2 / R3 / R4: nested calls and returns
    step("R2", 1, 0, 13'h0111);
    step("R2", 1, 0, 13'h0222);
    step("R2", 1, 0, 13'h0333);
    step("R4", 0, 1, '0);
    step("R4", 0, 1, '0);
    step("R3", 0, 1, '0);
    step("R3", 0, 0, '0);

    // R5: ten pushes overwrite the two oldest entries
    for (int i = 0; i < 10; i++) step("R5", 1, 0, DATA_W'(13'h1000 + i));
    // R5 / R6: pop ten times, last two wrap back to the newest values
    for (int i = 0; i < 8; i++) step("R5", 0, 1, '0);
    step("R6", 0, 1, '0);
    step("R6", 0, 1, '0);
    step("R6", 0, 0, '0);

    // R7: collision, push wins
    step("R7", 1, 1, 13'h1ABC);
    step("R7", 0, 0, '0);
    step("R7", 0, 1, '0);
    step("R7", 0, 0, '0);

    // R8: idle cycles keep the top
    @(negedge clk_i); #1 snap = pop_data_o;
    for (int i = 0; i < 4; i++) step("R8", 0, 0, DATA_W'($urandom));
    @(negedge clk_i); #1 check("R8", pop_data_o, snap);

    // R1: fill ring, partially overwrite, reset mid-run
    for (int i = 0; i < DEPTH + 3; i++) step("R1", 1, 0, DATA_W'(13'h0A00 + i));
    do_reset();
    #1 check("R1", pop_data_o, m_slot[DEPTH-1]);
    step("R1", 0, 1, '0);
    step("R1", 1, 0, 13'h0F0F);
    step("R1", 0, 0, '0);

    // random strobe mix
    for (int i = 0; i < 3000; i++) begin
      int unsigned r = $urandom % 8;
      step("R4", r < 3 || r == 7, r >= 3 && r != 6, DATA_W'($urandom));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule